// File: doc/BRIEF.md
# Reversible Star-Delta Motor Start Sequencer

This block controls a reversible three-phase induction motor that is started in star and then switched to delta. Three synchronised operator buttons feed it: run-left, run-right and stop. A press on one direction button closes that direction's line contactor. The contactor then holds itself through its own latch, and it blocks the opposite direction until stop is pressed. From the cycle a direction closes, the star contactor is closed.

The star contactor stays closed for a programmable number of timing ticks. Both winding contactors are then open for a programmable dead gap. After the gap the delta contactor closes and stays closed until stop.

Two internal tick counters time the star phase and the gap. Each counter is held at zero whenever its phase is not active, so every new start times both phases in full. The tick input is a slow enable from elsewhere in the chip, and it sets the time base. Every output is a register, and every output changes on the clock edge at which its cause is sampled.

Top module: `sdm_seq`

## Requirements
- R1: A left press from idle, with no stop press and no right press, sets `k_left` at the next edge. `k_left` then stays set with no button held until stop is pressed.
- R2: While one direction output is set, a press of the other direction button is ignored. `k_left` and `k_right` are never both set.
- R3: If both direction buttons are pressed in the same cycle while both direction outputs are clear, neither output sets.
- R4: `k_star` sets on the same edge as the direction output. It clears on the first edge after `star_time` ticks have been counted in the star phase. With `tick` high every cycle, that makes star last `star_time`+1 cycles.
- R5: `k_star` and `k_delta` are never set in the same cycle. A cycle with both clear always comes between them.
- R6: After star clears, both winding outputs stay clear until `gap_time` ticks have been counted. That is `gap_time`+1 cycles with `tick` high every cycle. `k_delta` then sets and stays set for as long as a direction output is set.
- R7: A stop press clears all four outputs at the next edge. Stop wins over a direction press made in the same cycle.
- R8: Both timers restart from zero on each new start. A star phase cut short by stop gives the next start a full star time.
- R9: The timers advance only on cycles with `tick` high. With `tick` held low, the star phase does not end.
- R10: While `rst_n` is low, all four outputs are clear, whatever the buttons do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing tick enable for both phase timers |
| btn_left | input | 1 | Run-left request, synchronised |
| btn_right | input | 1 | Run-right request, synchronised |
| btn_stop | input | 1 | Stop request, synchronised, dominant |
| star_time | input | TIMER_W | Star phase length in ticks |
| gap_time | input | TIMER_W | Dead-gap length in ticks |
| k_left | output | 1 | Left line contactor |
| k_right | output | 1 | Right line contactor |
| k_star | output | 1 | Star winding contactor |
| k_delta | output | 1 | Delta winding contactor |

## Verification
A cycle-by-cycle vector run covers several button patterns:
- A single start, which separates a self-holding latch from a momentary output.
- A press of the opposite button while running, which exposes a missing interlock.
- A press of the same button again during delta.
- Stop together with a direction press, which shows whether stop dominates.
- Simultaneous presses from idle.

The star and gap lengths are counted at the cycle level, so an off-by-one in either timer shows as a shift of one vector. Directed runs freeze `tick` low in star, abort a star phase and restart it, and watch star and delta for overlap on every cycle.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_STAR  = 2'd1,
      PH_GAP   = 2'd2,
      PH_DELTA = 2'd3
   } phase_e;
endpackage

// File: rtl/sdm_dir_latch.sv
// Self-holding direction latches with mutual lockout and dominant stop.
module sdm_dir_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_left,
   input  logic btn_right,
   input  logic btn_stop,
   output logic run_left_q,
   output logic run_right_q,
   output logic run_next
);
   logic idle;
   logic tie;
   logic left_d;
   logic right_d;

   assign idle = !run_left_q && !run_right_q;
   // simultaneous request from idle is refused (R3)
   assign tie  = idle && btn_left && btn_right;

   always_comb begin
      left_d  = !btn_stop && !tie && !run_right_q && (btn_left  || run_left_q);
      right_d = !btn_stop && !tie && !run_left_q  && (btn_right || run_right_q);
   end

   assign run_next = left_d || right_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_left_q  <= 1'b0;
         run_right_q <= 1'b0;
      end else begin
         run_left_q  <= left_d;
         run_right_q <= right_d;
      end
   end
endmodule

// File: rtl/sdm_timer.sv
// Saturating phase tick counter, held at zero while its phase is inactive.
module sdm_timer #(
   parameter int unsigned W          = 16,
   parameter bit          TICK_GATED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         tick,
   input  logic [W-1:0] preset,
   output logic         done
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic         step;

   generate
      if (TICK_GATED) begin : g_tick
         assign step = active && tick;
      end else begin : g_free
         logic unused_tick;
         assign unused_tick = tick;
         assign step = active;
      end
   endgenerate

   assign done = (cnt_q >= preset);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         cnt_q <= '0;
      end else if (step && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdm_phase.sv
// Winding phase sequencer: idle, star, dead gap, delta.
module sdm_phase
   import sdm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run_next,
   input  logic   star_done,
   input  logic   gap_done,
   output phase_e phase_q
);
   phase_e phase_d;

   always_comb begin
      phase_d = phase_q;
      if (!run_next) begin
         phase_d = PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_IDLE:  phase_d = PH_STAR;
            PH_STAR:  if (star_done) phase_d = PH_GAP;
            PH_GAP:   if (gap_done)  phase_d = PH_DELTA;
            PH_DELTA: phase_d = PH_DELTA;
            default:  phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end
endmodule

// File: rtl/sdm_seq.sv
// Top: reversible star-delta start sequencer.
module sdm_seq
   import sdm_pkg::*;
#(
   parameter int unsigned TIMER_W    = 16,
   parameter bit          TICK_GATED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               btn_left,
   input  logic               btn_right,
   input  logic               btn_stop,
   input  logic [TIMER_W-1:0] star_time,
   input  logic [TIMER_W-1:0] gap_time,
   output logic               k_left,
   output logic               k_right,
   output logic               k_star,
   output logic               k_delta
);
   generate
      if (TIMER_W < 2 || TIMER_W > 32) begin : g_bad_width
         $error("sdm_seq: TIMER_W must lie in 2..32");
      end
   endgenerate

   logic   run_left_q;
   logic   run_right_q;
   logic   run_next;
   logic   star_done;
   logic   gap_done;
   phase_e phase_q;

   sdm_dir_latch u_dir (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_left    (btn_left),
      .btn_right   (btn_right),
      .btn_stop    (btn_stop),
      .run_left_q  (run_left_q),
      .run_right_q (run_right_q),
      .run_next    (run_next)
   );

   sdm_timer #(.W(TIMER_W), .TICK_GATED(TICK_GATED)) u_star_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (phase_q == PH_STAR),
      .tick   (tick),
      .preset (star_time),
      .done   (star_done)
   );

   sdm_timer #(.W(TIMER_W), .TICK_GATED(TICK_GATED)) u_gap_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (phase_q == PH_GAP),
      .tick   (tick),
      .preset (gap_time),
      .done   (gap_done)
   );

   sdm_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_next  (run_next),
      .star_done (star_done),
      .gap_done  (gap_done),
      .phase_q   (phase_q)
   );

   assign k_left  = run_left_q;
   assign k_right = run_right_q;
   assign k_star  = (phase_q == PH_STAR);
   assign k_delta = (phase_q == PH_DELTA);
endmodule

// File: rtl/sdm_seq_chk.sv
module sdm_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic btn_stop,
   input logic k_left,
   input logic k_right,
   input logic k_star,
   input logic k_delta
);
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (k_left && !btn_stop) |=> k_left); // R1
   AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(k_left && k_right)); // R2
   AST_STAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(k_left || k_right) |-> k_star); // R4
   AST_WIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(k_star && k_delta)); // R5
   AST_GAP_BEFORE_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(k_delta) |-> (!$past(k_star) && !$past(k_delta))); // R5
   AST_DELTA_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      k_delta |-> (k_left || k_right)); // R6
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      btn_stop |=> !(k_left || k_right || k_star || k_delta)); // R7
endmodule

bind sdm_seq sdm_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .btn_stop (btn_stop),
   .k_left   (k_left),
   .k_right  (k_right),
   .k_star   (k_star),
   .k_delta  (k_delta)
);

// File: tb/sdm_seq_tb_top.sv
module sdm_seq_tb_top;
   localparam int TW    = 8;
   localparam int NVEC  = 14;
   localparam int STAR_P = 2;   // star lasts 3 cycles with tick held high
   localparam int GAP_P  = 1;   // gap lasts 2 cycles with tick held high

   // {btn_left, btn_right, btn_stop, exp_left, exp_right, exp_star, exp_delta}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b000_0000, // 0  idle                              R10
      7'b100_1010, // 1  left start, star at once          R1 R4
      7'b000_1010, // 2  held, star                        R1
      7'b010_1010, // 3  right press blocked               R2
      7'b000_1000, // 4  gap after star_time ticks         R4 R5
      7'b000_1000, // 5  gap                               R6
      7'b000_1001, // 6  delta                             R6
      7'b100_1001, // 7  repeat left press, no change      R6
      7'b001_0000, // 8  stop                              R7
      7'b010_0110, // 9  right start                       R2
      7'b000_0110, // 10 right held
      7'b011_0000, // 11 stop with right press             R7
      7'b110_0000, // 12 both buttons from idle            R3
      7'b000_0000  // 13 still idle                        R3
   };
   localparam int VTAG [NVEC] = '{10, 1, 1, 2, 4, 6, 6, 6, 7, 2, 2, 7, 3, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic          btn_left = 1'b0;
   logic          btn_right = 1'b0;
   logic          btn_stop = 1'b0;
   logic [TW-1:0] star_time = TW'(STAR_P);
   logic [TW-1:0] gap_time  = TW'(GAP_P);
   logic          k_left, k_right, k_star, k_delta;

   int checks = 0;
   int errors = 0;
   int overlap = 0;

   always #2 clk = ~clk;

   sdm_seq #(.TIMER_W(TW)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .btn_left  (btn_left),
      .btn_right (btn_right),
      .btn_stop  (btn_stop),
      .star_time (star_time),
      .gap_time  (gap_time),
      .k_left    (k_left),
      .k_right   (k_right),
      .k_star    (k_star),
      .k_delta   (k_delta)
   );

   // R5 overlap monitor, sampled away from the edge
   always @(negedge clk) if (rst_n && k_star && k_delta) overlap++;

   function automatic logic [3:0] outs();
      return {k_left, k_right, k_star, k_delta};
   endfunction

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input logic l, input logic r, input logic s);
      @(negedge clk);
      btn_left = l; btn_right = r; btn_stop = s;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R10: reset holds outputs clear even with buttons pressed
      btn_left = 1'b1;
      repeat (3) @(posedge clk);
      #1 chk("R10 reset", outs(), 4'b0000);
      @(negedge clk);
      btn_left = 1'b0;
      rst_n = 1'b1;

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][6], VEC[i][5], VEC[i][4]);
         chk($sformatf("R%0d vec%0d", VTAG[i], i), outs(), VEC[i][3:0]);
      end

      // R8: abort star early, restart gets full star time
      step(1, 0, 0);
      step(0, 0, 0);
      step(0, 0, 1);
      step(1, 0, 0);
      chk("R8 restart star", outs(), 4'b1010);
      step(0, 0, 0);
      step(0, 0, 0);
      chk("R8 star still on after 3 cycles", outs(), 4'b1010);
      step(0, 0, 0);
      chk("R8 gap after full star", outs(), 4'b1000);
      step(0, 0, 1);

      // R9: tick frozen low keeps star on
      tick = 1'b0;
      step(0, 1, 0);
      for (int k = 0; k < 10; k++) step(0, 0, 0);
      chk("R9 star held without ticks", outs(), 4'b0110);
      tick = 1'b1;
      for (int k = 0; k < 8; k++) step(0, 0, 0);
      chk("R6 delta reached", outs(), 4'b0101);
      for (int k = 0; k < 20; k++) step(0, 0, 0);
      chk("R6 delta holds", outs(), 4'b0101);
      step(1, 0, 0);
      chk("R2 left blocked in delta", outs(), 4'b0101);
      step(0, 0, 1);
      chk("R7 stop from delta", outs(), 4'b0000);

      // R4: zero star preset gives one cycle of star
      star_time = '0;
      step(1, 0, 0);
      chk("R4 zero preset star", outs(), 4'b1010);
      step(0, 0, 0);
      chk("R4 zero preset gap", outs(), 4'b1000);
      step(0, 0, 1);

      checks++;
      if (overlap != 0) begin
         errors++;
         $display("FAIL R5 overlap: got %0d expected 0", overlap);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule